// File: doc/BRIEF.md
# Descriptor Ring Transmit/Receive Channel Engine

This block is the hardware half of one network channel that moves frames through descriptor rings shared with software. Descriptors live in an internal RAM that software fills and inspects through a simple word-addressed host port. Each descriptor is two words: a buffer address and a flags word. The flags word holds an ownership bit, start-of-frame and end-of-frame marks, and a length. Software hands a descriptor to the engine by setting its ownership bit. The engine hands it back by clearing that bit.

On the transmit side, a wake-up doorbell makes the engine walk the transmit ring from its current index. For each owned descriptor it presents the buffer address, length and frame marks on a valid/ready output stream. After the handshake it releases the descriptor. It stops at the first descriptor it does not own. On the receive side, a valid/ready input stream delivers one frame length per transfer. The engine writes that length plus the 4-byte check sequence into the next owned receive descriptor and releases it. If that descriptor is not owned, the frame is dropped and a sticky drop flag is set. Both rings start at software-chosen descriptor indices and wrap at a power-of-two ring size. A release raises a one-cycle interrupt pulse, which a per-direction mask can suppress.

Back-pressure rules: on the transmit stream, address, length and marks stay stable while `tx_valid` is high and `tx_ready` is low. The only exception is a soft channel reset, which withdraws `tx_valid`. On the receive stream, `rx_ready` is high only while the receive engine is idle. Each accepted frame therefore drops `rx_ready` for one cycle.

Top module: `dring_chan`

## Requirements
- R1: After `rst_n` is released, `tx_valid`, `tx_irq` and `rx_irq` are 0 and `rx_ready` is 1. Every descriptor word reads 0. Both mask registers read 1 (masked). The status and control registers read 0.
- R2: Host addresses with bit 7 = 0 select descriptor RAM. Bits 6:1 give the descriptor index, and bit 0 selects the address word (0) or the flags word (1). A write is visible on `host_rdata` in the cycle after its clock edge. `host_rdata` follows `host_addr` combinationally.
- R3: Registers sit at host address 0x80 + n. The registers are: control (n=0), receive ring base (n=1), transmit ring base (n=2), receive mask (n=3), transmit mask (n=4) and status (n=5). Writing control with bit 0 = 1 is a transmit doorbell. If the descriptor at the current transmit index has flags bit 31 (ownership) set, `tx_valid` rises two clock edges after the doorbell write edge. At that point `tx_addr` is the address word, `tx_len` is flags bits 11:0, `tx_sop` is flags bit 30 and `tx_eop` is flags bit 29.
- R4: The transmit engine presents only descriptors whose ownership bit is 1. A doorbell with no owned descriptor at the current index produces no `tx_valid`. A scan ends at the first non-owned descriptor.
- R5: While `tx_valid` is high and `tx_ready` is low, the transmit outputs hold. One edge after the handshake edge, the descriptor's flags word reads back with bit 31 cleared and every other bit unchanged. The transmit index then advances by one.
- R6: A one-cycle `tx_irq` pulse appears one edge after the handshake edge when transmit mask bit 0 is 0. No pulse appears when the mask bit is 1.
- R7: A frame accepted on `rx_valid`/`rx_ready` with an owned descriptor is written back one edge after the accept edge. The write-back clears bit 31, sets bits 11:0 to `rx_len` + 4 modulo 4096, and keeps every other flags bit and the address word. `rx_ready` is 0 for the cycle between the two edges.
- R8: A one-cycle `rx_irq` pulse accompanies each receive release when receive mask bit 0 is 0. No pulse appears when the mask bit is 1.
- R9: A frame that finds the current receive descriptor not owned is consumed without a write. The receive index does not move and no interrupt is raised. Status bit 0 becomes 1 one edge after the accept edge. Writing 1 to status bit 0 clears it.
- R10: Ring entry k lives at descriptor (base + k) mod 64. The transmit and receive indices each wrap at their ring size (16 by default).
- R11: Writing control with bit 1 = 1 is a soft reset. From the next cycle it drops `tx_valid` and reads back as control bit 1 for exactly one cycle. It also zeroes both ring indices, cancels a pending doorbell and clears the drop flag.
- R12: A host write to descriptor RAM has priority over a release. A release due in a cycle with a host RAM write waits until the first cycle without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host word address (RAM or register) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational read data for `host_addr` |
| tx_valid | output | 1 | Transmit descriptor presented |
| tx_ready | input | 1 | Transmit sink accepts |
| tx_addr | output | 32 | Buffer address of presented descriptor |
| tx_len | output | 12 | Length field of presented descriptor |
| tx_sop | output | 1 | Start-of-frame mark |
| tx_eop | output | 1 | End-of-frame mark |
| rx_valid | input | 1 | Received frame offered |
| rx_ready | output | 1 | Receive engine can accept a frame |
| rx_len | input | 12 | Received frame length without check sequence |
| tx_irq | output | 1 | Transmit release pulse (maskable) |
| rx_irq | output | 1 | Receive release pulse (maskable) |

## Verification
Every result has a fixed latency, counted in clock edges from its cause:
- `tx_valid` rises two edges after the doorbell write edge.
- The transmit release and its interrupt come one edge after the handshake edge.
- The receive write-back, its interrupt and the drop flag come one edge after the accept edge.
- A soft reset takes effect in the cycle right after its write edge.

The bench drives inputs and samples outputs on falling edges, so each check falls in the half cycle after the edge that produces the result. The bench also samples the cycle before that edge where a result must not yet be present, for example while a host write is stalling a receive release. Random ready delays, lengths, masks and ownership patterns are drawn from a seeded generator. Expected flags words and ring slots are computed by bench functions.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int WORD_W  = 32;
  localparam int OWN_BIT = 31;
  localparam int SOP_BIT = 30;
  localparam int EOP_BIT = 29;
  localparam int FCS_BYTES = 4;

  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_RXBASE = 3'd1;
  localparam logic [2:0] REG_TXBASE = 3'd2;
  localparam logic [2:0] REG_RXMASK = 3'd3;
  localparam logic [2:0] REG_TXMASK = 3'd4;
  localparam logic [2:0] REG_STATUS = 3'd5;

  localparam int CTRL_WAKE = 0;
  localparam int CTRL_RST  = 1;

  typedef enum logic [1:0] {TX_IDLE, TX_SCAN, TX_SEND, TX_REL} tx_state_e;
  typedef enum logic {RX_IDLE, RX_HOLD} rx_state_e;
endpackage

// File: rtl/dring_regs.sv
module dring_regs
  import dring_pkg::*;
#(
  parameter int DIDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              drop_set,
  output logic [DIDX_W-1:0] rx_base,
  output logic [DIDX_W-1:0] tx_base,
  output logic              rx_mask,
  output logic              tx_mask,
  output logic              wake,
  output logic              soft_rst,
  output logic [WORD_W-1:0] rdata
);
  logic drop_q;
  logic unused_bits;
  assign unused_bits = ^wdata[WORD_W-1:DIDX_W];

  assign wake = we && (addr == REG_CTRL) && wdata[CTRL_WAKE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_base  <= '0;
      tx_base  <= '0;
      rx_mask  <= 1'b1;
      tx_mask  <= 1'b1;
      soft_rst <= 1'b0;
      drop_q   <= 1'b0;
    end else begin
      soft_rst <= we && (addr == REG_CTRL) && wdata[CTRL_RST];
      if (we) begin
        case (addr)
          REG_RXBASE: rx_base <= wdata[DIDX_W-1:0];
          REG_TXBASE: tx_base <= wdata[DIDX_W-1:0];
          REG_RXMASK: rx_mask <= wdata[0];
          REG_TXMASK: tx_mask <= wdata[0];
          default: ;
        endcase
      end
      if (soft_rst)
        drop_q <= 1'b0;
      else if (drop_set)
        drop_q <= 1'b1;
      else if (we && (addr == REG_STATUS) && wdata[0])
        drop_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      REG_CTRL:   rdata = WORD_W'({soft_rst, 1'b0});
      REG_RXBASE: rdata = WORD_W'(rx_base);
      REG_TXBASE: rdata = WORD_W'(tx_base);
      REG_RXMASK: rdata = WORD_W'(rx_mask);
      REG_TXMASK: rdata = WORD_W'(tx_mask);
      REG_STATUS: rdata = WORD_W'(drop_q);
      default:    rdata = '0;
    endcase
  end

  // R11: the reset strobe never lasts beyond the cycle after its last write
  a_r11_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && !(we && addr == REG_CTRL) |=> !soft_rst);

  // R9: a drop seen outside soft reset leaves the flag set
  a_r9_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    drop_set && !soft_rst |=> drop_q);
endmodule

// File: rtl/dring_desc_mem.sv
module dring_desc_mem
  import dring_pkg::*;
#(
  parameter int DESC_N = 64,
  localparam int DIDX_W = $clog2(DESC_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [DIDX_W-1:0] host_idx,
  input  logic              host_word,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              tx_we,
  input  logic [DIDX_W-1:0] tx_idx,
  input  logic [WORD_W-1:0] tx_wdata,
  output logic [WORD_W-1:0] tx_addr_rd,
  output logic [WORD_W-1:0] tx_flags_rd,
  input  logic              rx_we,
  input  logic [DIDX_W-1:0] rx_idx,
  input  logic [WORD_W-1:0] rx_wdata,
  output logic [WORD_W-1:0] rx_flags_rd
);
  logic [WORD_W-1:0] addr_mem [DESC_N];
  logic [WORD_W-1:0] flag_mem [DESC_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DESC_N; i++) begin
        addr_mem[i] <= '0;
        flag_mem[i] <= '0;
      end
    end else begin
      if (tx_we) flag_mem[tx_idx] <= tx_wdata;
      if (rx_we) flag_mem[rx_idx] <= rx_wdata;
      if (host_we) begin
        if (host_word) flag_mem[host_idx] <= host_wdata;
        else           addr_mem[host_idx] <= host_wdata;
      end
    end
  end

  assign host_rdata  = host_word ? flag_mem[host_idx] : addr_mem[host_idx];
  assign tx_addr_rd  = addr_mem[tx_idx];
  assign tx_flags_rd = flag_mem[tx_idx];
  assign rx_flags_rd = flag_mem[rx_idx];

  // R12: engines never write in a cycle the host writes the RAM
  a_r12_host_first: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |-> !(tx_we || rx_we));
endmodule

// File: rtl/dring_tx_eng.sv
module dring_tx_eng
  import dring_pkg::*;
#(
  parameter int DIDX_W = 6,
  parameter int RING   = 16,
  parameter int LEN_W  = 12,
  localparam int IDX_W = $clog2(RING)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wake,
  input  logic [DIDX_W-1:0] base,
  input  logic              mask,
  input  logic              stall,
  output logic [DIDX_W-1:0] ptr,
  input  logic [WORD_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_flags,
  output logic              we,
  output logic [WORD_W-1:0] wdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_addr,
  output logic [LEN_W-1:0]  tx_len,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic              irq
);
  tx_state_e         st;
  logic [IDX_W-1:0]  idx;
  logic              pend;
  logic [WORD_W-1:0] cap_addr;
  logic [WORD_W-1:0] cap_flags;

  assign ptr = base + DIDX_W'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= TX_IDLE;
      idx       <= '0;
      pend      <= 1'b0;
      irq       <= 1'b0;
      cap_addr  <= '0;
      cap_flags <= '0;
    end else if (clr) begin
      st   <= TX_IDLE;
      idx  <= '0;
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq  <= 1'b0;
      pend <= pend | wake;
      case (st)
        TX_IDLE: if (pend) begin
          st   <= TX_SCAN;
          pend <= wake;
        end
        TX_SCAN: if (rd_flags[OWN_BIT]) begin
          st        <= TX_SEND;
          cap_addr  <= rd_addr;
          cap_flags <= rd_flags;
        end else begin
          st <= TX_IDLE;
        end
        TX_SEND: if (tx_ready) st <= TX_REL;
        TX_REL: if (!stall) begin
          st  <= TX_SCAN;
          idx <= idx + IDX_W'(1);
          irq <= !mask;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    wdata          = cap_flags;
    wdata[OWN_BIT] = 1'b0;
  end

  assign we       = (st == TX_REL) && !stall && !clr;
  assign tx_valid = (st == TX_SEND) && !clr;
  assign tx_addr  = cap_addr;
  assign tx_len   = cap_flags[LEN_W-1:0];
  assign tx_sop   = cap_flags[SOP_BIT];
  assign tx_eop   = cap_flags[EOP_BIT];

  // R5: presented descriptor holds under back-pressure
  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n || clr)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_addr) && $stable(tx_len)
      && $stable(tx_sop) && $stable(tx_eop));

  // R4: a presentation only follows a scan that saw the ownership bit
  a_r4_owned_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(rd_flags[OWN_BIT]));

  // R6: interrupt is a single-cycle pulse
  a_r6_tx_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R11: soft reset withdraws the stream
  a_r11_tx_abort: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !tx_valid);
endmodule

// File: rtl/dring_rx_eng.sv
module dring_rx_eng
  import dring_pkg::*;
#(
  parameter int DIDX_W = 6,
  parameter int RING   = 16,
  parameter int LEN_W  = 12,
  localparam int IDX_W = $clog2(RING)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [DIDX_W-1:0] base,
  input  logic              mask,
  input  logic              stall,
  output logic [DIDX_W-1:0] ptr,
  input  logic [WORD_W-1:0] rd_flags,
  output logic              we,
  output logic [WORD_W-1:0] wdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [LEN_W-1:0]  rx_len,
  output logic              drop_set,
  output logic              irq
);
  rx_state_e        st;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] len_q;

  assign ptr = base + DIDX_W'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RX_IDLE;
      idx   <= '0;
      len_q <= '0;
      irq   <= 1'b0;
    end else if (clr) begin
      st  <= RX_IDLE;
      idx <= '0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (st)
        RX_IDLE: if (rx_valid) begin
          st    <= RX_HOLD;
          len_q <= rx_len;
        end
        RX_HOLD: if (!rd_flags[OWN_BIT]) begin
          st <= RX_IDLE;
        end else if (!stall) begin
          st  <= RX_IDLE;
          idx <= idx + IDX_W'(1);
          irq <= !mask;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    wdata                = rd_flags;
    wdata[OWN_BIT]       = 1'b0;
    wdata[LEN_W-1:0]     = len_q + LEN_W'(FCS_BYTES);
  end

  assign rx_ready = (st == RX_IDLE) && !clr;
  assign we       = (st == RX_HOLD) && rd_flags[OWN_BIT] && !stall && !clr;
  assign drop_set = (st == RX_HOLD) && !rd_flags[OWN_BIT] && !clr;

  // R7: one frame is taken at a time
  a_r7_one_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready |=> !rx_ready);

  // R8: interrupt only when the mask was clear at release
  a_r8_rx_irq_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !$past(mask));

  // R8: single-cycle pulse
  a_r8_rx_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: rtl/dring_chan.sv
module dring_chan
  import dring_pkg::*;
#(
  parameter int DESC_N  = 64,
  parameter int TX_RING = 16,
  parameter int RX_RING = 16,
  parameter int LEN_W   = 12,
  localparam int DIDX_W = $clog2(DESC_N),
  localparam int HA_W   = DIDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [HA_W-1:0]   host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_addr,
  output logic [LEN_W-1:0]  tx_len,
  output logic              tx_sop,
  output logic              tx_eop,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [LEN_W-1:0]  rx_len,
  output logic              tx_irq,
  output logic              rx_irq
);
  logic              sel_reg;
  logic              ram_we;
  logic              reg_we;
  logic [WORD_W-1:0] reg_rdata;
  logic [WORD_W-1:0] ram_rdata;
  logic [DIDX_W-1:0] rx_base, tx_base;
  logic              rx_mask, tx_mask, wake, soft_rst, drop_set;
  logic [DIDX_W-1:0] tx_ptr, rx_ptr;
  logic [WORD_W-1:0] tx_rd_addr, tx_rd_flags, rx_rd_flags;
  logic              tx_we, rx_we;
  logic [WORD_W-1:0] tx_wdata, rx_wdata;

  assign sel_reg    = host_addr[HA_W-1];
  assign ram_we     = host_wr && !sel_reg;
  assign reg_we     = host_wr && sel_reg;
  assign host_rdata = sel_reg ? reg_rdata : ram_rdata;

  dring_regs #(.DIDX_W(DIDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(host_addr[2:0]),
    .wdata(host_wdata), .drop_set(drop_set), .rx_base(rx_base),
    .tx_base(tx_base), .rx_mask(rx_mask), .tx_mask(tx_mask),
    .wake(wake), .soft_rst(soft_rst), .rdata(reg_rdata)
  );

  dring_desc_mem #(.DESC_N(DESC_N)) u_mem (
    .clk(clk), .rst_n(rst_n), .host_we(ram_we),
    .host_idx(host_addr[DIDX_W:1]), .host_word(host_addr[0]),
    .host_wdata(host_wdata), .host_rdata(ram_rdata),
    .tx_we(tx_we), .tx_idx(tx_ptr), .tx_wdata(tx_wdata),
    .tx_addr_rd(tx_rd_addr), .tx_flags_rd(tx_rd_flags),
    .rx_we(rx_we), .rx_idx(rx_ptr), .rx_wdata(rx_wdata),
    .rx_flags_rd(rx_rd_flags)
  );

  dring_tx_eng #(.DIDX_W(DIDX_W), .RING(TX_RING), .LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .wake(wake), .base(tx_base),
    .mask(tx_mask), .stall(ram_we), .ptr(tx_ptr), .rd_addr(tx_rd_addr),
    .rd_flags(tx_rd_flags), .we(tx_we), .wdata(tx_wdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_addr(tx_addr),
    .tx_len(tx_len), .tx_sop(tx_sop), .tx_eop(tx_eop), .irq(tx_irq)
  );

  dring_rx_eng #(.DIDX_W(DIDX_W), .RING(RX_RING), .LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .base(rx_base),
    .mask(rx_mask), .stall(ram_we), .ptr(rx_ptr), .rd_flags(rx_rd_flags),
    .we(rx_we), .wdata(rx_wdata), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_len(rx_len), .drop_set(drop_set), .irq(rx_irq)
  );

  initial begin
    assert (TX_RING <= DESC_N && RX_RING <= DESC_N && TX_RING >= 2 && RX_RING >= 2);
  end
endmodule

// File: tb/tb_dring_chan.sv
`timescale 1ns/1ps
module tb_dring_chan;
  localparam logic [7:0] A_CTRL = 8'h80, A_RXBASE = 8'h81, A_TXBASE = 8'h82,
                         A_RXMASK = 8'h83, A_TXMASK = 8'h84, A_STATUS = 8'h85;
  localparam int TXB = 56, RXB = 8;
  localparam logic [31:0] OWN = 32'h8000_0000;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0;
  logic [7:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic tx_valid, tx_ready = 0, tx_sop, tx_eop;
  logic [31:0] tx_addr;
  logic [11:0] tx_len;
  logic rx_valid = 0, rx_ready;
  logic [11:0] rx_len = 0;
  logic tx_irq, rx_irq;

  int nchk = 0, nerr = 0;
  int tx_i = 0, rx_i = 0;
  bit done = 0;
  logic [31:0] ea [4];
  logic [31:0] ef [4];

  always #10 clk = ~clk;

  dring_chan dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_addr(tx_addr), .tx_len(tx_len), .tx_sop(tx_sop),
    .tx_eop(tx_eop), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_len(rx_len),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  function automatic int slot(input int base, input int i);
    return (base + i) % 64;
  endfunction
  function automatic logic [7:0] ram(input int d, input bit w);
    return {1'b0, 6'(d), w};
  endfunction
  function automatic logic [31:0] rx_exp(input logic [31:0] f, input logic [11:0] l);
    logic [31:0] r = f;
    r[31] = 1'b0;
    r[11:0] = l + 12'd4;
    return r;
  endfunction
  function automatic logic [31:0] tx_rel(input logic [31:0] f);
    return f & ~OWN;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask
  task automatic hw(input logic [7:0] a, input logic [31:0] d);
    host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
  endtask
  task automatic hr(input logic [7:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic tx_take(input logic [31:0] a, input logic [31:0] f,
                         input bit irq_e, input int s);
    int w = 0;
    int d;
    logic [31:0] rd;
    while (!tx_valid && w < 30) begin @(negedge clk); w++; end
    if (!tx_valid) begin chk("R3 tx_valid rise", 0, 1); return; end
    chk("R3/R10 tx_addr", tx_addr, a);
    chk("R3 tx_len", 32'(tx_len), 32'(f[11:0]));
    chk("R3 tx_sop", 32'(tx_sop), 32'(f[30]));
    chk("R3 tx_eop", 32'(tx_eop), 32'(f[29]));
    d = $urandom_range(0, 3);
    repeat (d) begin
      @(negedge clk);
      chk("R5 hold valid", 32'(tx_valid), 1);
      chk("R5 hold addr", tx_addr, a);
    end
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
    @(negedge clk);
    chk("R6 tx_irq", 32'(tx_irq), 32'(irq_e));
    hr(ram(slot(TXB, s), 1), rd);
    chk("R5 released flags", rd, tx_rel(f));
  endtask

  task automatic rx_frame(input logic [11:0] l, input bit owned, input bit msk,
                          input bit clr_drop);
    logic [31:0] a, f, rd;
    int p;
    p = slot(RXB, rx_i);
    a = $urandom; f = $urandom; f[31] = owned;
    hw(A_RXMASK, 32'(msk));
    hw(ram(p, 0), a);
    hw(ram(p, 1), f);
    rx_len = l; rx_valid = 1;
    chk("R7 rx_ready idle", 32'(rx_ready), 1);
    @(negedge clk);
    rx_valid = 0;
    chk("R7 rx_ready busy", 32'(rx_ready), 0);
    @(negedge clk);
    chk("R8 rx_irq", 32'(rx_irq), 32'(owned && !msk));
    hr(ram(p, 1), rd);
    if (owned) chk("R7/R10 rx flags", rd, rx_exp(f, l));
    else       chk("R9 flags untouched", rd, f);
    hr(ram(p, 0), rd);
    chk("R7 rx addr kept", rd, a);
    hr(A_STATUS, rd);
    chk("R9 drop flag", 32'(rd[0]), 32'(!owned));
    if (!owned && clr_drop) begin
      hw(A_STATUS, 1);
      hr(A_STATUS, rd);
      chk("R9 drop cleared", 32'(rd[0]), 0);
    end
    if (owned) rx_i = (rx_i + 1) % 16;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int tmp;
    tmp = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 tx_valid", 32'(tx_valid), 0);
    chk("R1 rx_ready", 32'(rx_ready), 1);
    chk("R1 irqs", 32'({tx_irq, rx_irq}), 0);
    hr(A_RXMASK, rd); chk("R1 rx mask", rd, 1);
    hr(A_TXMASK, rd); chk("R1 tx mask", rd, 1);
    hr(A_STATUS, rd); chk("R1 status", rd, 0);
    hr(A_CTRL, rd);   chk("R1 ctrl", rd, 0);
    hr(ram(5, 1), rd); chk("R1 ram clear", rd, 0);
    // R2
    hw(ram(30, 0), 32'hCAFE_0123);
    hw(ram(30, 1), 32'h1234_5678);
    hr(ram(30, 0), rd); chk("R2 addr word", rd, 32'hCAFE_0123);
    hr(ram(30, 1), rd); chk("R2 flags word", rd, 32'h1234_5678);
    hw(A_TXBASE, TXB);
    hw(A_RXBASE, RXB);
    hr(A_TXBASE, rd); chk("R10 tx base", rd, TXB);
    hw(A_TXMASK, 0);
    hw(A_RXMASK, 0);
    // R4: doorbell with nothing owned
    hw(A_CTRL, 1);
    tmp = 0;
    repeat (8) begin @(negedge clk); if (tx_valid) tmp++; end
    chk("R4 no owned descriptor", tmp, 0);

    // random transmit rounds, wrapping the ring across RAM end
    for (int r = 0; r < 10; r++) begin
      int n;
      bit msk;
      n = $urandom_range(1, 4);
      msk = (r == 4);
      hw(A_TXMASK, 32'(msk));
      for (int k = 0; k < n; k++) begin
        ea[k] = $urandom;
        ef[k] = ($urandom & 32'h1FFF_F000) | OWN | 32'($urandom_range(0, 4095));
        ef[k][30] = ($urandom_range(0, 3) != 0);
        ef[k][29] = ($urandom_range(0, 3) != 0);
        hw(ram(slot(TXB, (tx_i + k) % 16), 0), ea[k]);
        hw(ram(slot(TXB, (tx_i + k) % 16), 1), ef[k]);
      end
      hw(A_CTRL, 1);
      for (int k = 0; k < n; k++) begin
        tx_take(ea[k], ef[k], !msk, tx_i);
        tx_i = (tx_i + 1) % 16;
      end
      tmp = 0;
      repeat (5) begin @(negedge clk); if (tx_valid) tmp++; end
      chk("R4 scan stops at unowned", tmp, 0);
    end
    hw(A_TXMASK, 0);

    // receive: directed length wrap, then random frames
    rx_frame(12'd4094, 1, 0, 1);
    rx_frame(12'd60, 0, 0, 1);
    for (int f = 0; f < 26; f++)
      rx_frame(12'($urandom_range(0, 1600)), ($urandom_range(0, 4) != 0),
               ($urandom_range(0, 3) == 0), 1);
    hw(A_RXMASK, 0);

    // R12: host RAM writes stall a receive release
    begin
      logic [31:0] a, f;
      int p;
      p = slot(RXB, rx_i);
      a = $urandom; f = $urandom | OWN;
      hw(ram(p, 0), a);
      hw(ram(p, 1), f);
      rx_len = 12'd100; rx_valid = 1;
      @(negedge clk);
      rx_valid = 0;
      host_addr = ram(40, 0); host_wdata = 32'h5555_AAAA; host_wr = 1;
      @(negedge clk);
      @(negedge clk);
      host_wr = 0;
      chk("R12 stalled no irq", 32'(rx_irq), 0);
      hr(ram(p, 1), rd); chk("R12 stalled still owned", rd, f);
      @(negedge clk);
      chk("R12 release after stall irq", 32'(rx_irq), 1);
      hr(ram(p, 1), rd); chk("R12 release after stall", rd, rx_exp(f, 12'd100));
      hr(ram(40, 0), rd); chk("R12 host write kept", rd, 32'h5555_AAAA);
      rx_i = (rx_i + 1) % 16;
    end

    // R11: soft reset
    rx_frame(12'd64, 0, 0, 0);
    hw(ram(slot(TXB, tx_i), 0), 32'h1111_0000);
    hw(ram(slot(TXB, tx_i), 1), OWN | 32'h6000_0040);
    hw(ram(slot(TXB, (tx_i + 1) % 16), 1), OWN | 32'h6000_0041);
    hw(A_CTRL, 1);
    tmp = 0;
    while (!tx_valid && tmp < 30) begin @(negedge clk); tmp++; end
    chk("R3 valid before reset", 32'(tx_valid), 1);
    hw(A_CTRL, 2);
    chk("R11 tx_valid dropped", 32'(tx_valid), 0);
    hr(A_CTRL, rd); chk("R11 ctrl bit1 set", rd, 2);
    @(negedge clk);
    hr(A_CTRL, rd); chk("R11 ctrl bit1 self-clears", rd, 0);
    hr(A_STATUS, rd); chk("R11 drop cleared", rd, 0);
    chk("R11 no tx after reset", 32'(tx_valid), 0);
    hw(ram(slot(TXB, tx_i), 1), 0);
    hw(ram(slot(TXB, (tx_i + 1) % 16), 1), 0);
    tx_i = 0; rx_i = 0;
    hw(ram(slot(TXB, 0), 0), 32'hABCD_0000);
    hw(ram(slot(TXB, 0), 1), OWN | 32'h6000_0123);
    hw(A_CTRL, 1);
    tx_take(32'hABCD_0000, OWN | 32'h6000_0123, 1, 0);
    rx_frame(12'd200, 1, 0, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule